// File: doc/BRIEF.md
# PATA PIO Cycle Timer

This block produces the read and write strobes for parallel ATA programmed I/O on two channels. Each channel serves a master and a slave drive, so there are four drive units in all, numbered `2*channel + device`. Each unit has its own 16-bit timing word. The low byte sets the read cycle and the high byte sets the write cycle. In each byte the two nibbles are stored inverted: the low nibble holds 17 minus the active clocks and the high nibble holds 16 minus the recovery clocks.

Software sets these words through a byte-wide configuration port. The same port holds a per-unit flag that bypasses IORDY flow control and a read-only status byte showing which channels have a write cycle in flight.

To run a cycle, a host-side sequencer raises a request on a channel together with the device select and the direction. The block then holds the matching strobe low for the active time, releases it for the recovery time, and pulses a done flag for one cycle. If a unit's bypass flag is clear, the active phase also waits for the synchronized IORDY input to be high.

Top module: `pata_pio_timer`

## Requirements
- R1: After reset, every timing byte (addresses 0x44 to 0x4B) reads 0x00, the enable byte (0x42) and the status byte (0x43) read 0x00, both strobes on both channels are high and `cycDone` is low.
- R2: A read request accepted at clock edge k drives `diorN[ch]` low from edge k to edge k+A, where A = 17 − (bits 3:0 of the unit's low byte at 0x44+2·unit).
- R3: After the active phase the strobe stays high for R = 16 − (bits 7:4 of the selected byte) cycles. `cycDone[ch]` then goes high for exactly one cycle. A request is accepted only while the channel is idle, which includes the cycle in which `cycDone` is high.
- R4: A write request uses the unit's high byte (address 0x45+2·unit) with the same nibble layout and drives `diowN[ch]`. The other strobe of the channel stays high for the whole cycle.
- R5: A nibble of 0x0 gives the longest phases (17 active, 16 recovery) and a nibble of 0xF gives the shortest (2 active, 1 recovery).
- R6: When the unit's enable bit (bit 4+unit of 0x42) is clear, the active phase lasts until its count has elapsed and the two-flop synchronized IORDY is high. The strobe releases on the third rising edge after IORDY rises. When the bit is set, IORDY is ignored.
- R7: Status bit ch of 0x43 reads 1 while a write cycle is running on channel ch and reads 0 once the channel is idle.
- R8: A write to 0x42 is ignored while any status bit is 1. It takes effect when both channels are free of write cycles.
- R9: A timing byte written while a cycle is running does not change that cycle. It applies from the next request onward.
- R10: The two channels run independently: requests accepted on the same edge complete, each with its own unit's timing.
- R11: `cycDev[ch]` selects unit 2·ch + dev, and only that unit's timing word and enable bit are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte address |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data (combinational on `cfgAddr`) |
| cycReq | input | 2 | Per-channel cycle request |
| cycDev | input | 2 | Per-channel device select (0 master, 1 slave) |
| cycWrite | input | 2 | Per-channel direction (1 write) |
| iordy | input | 2 | Per-channel IORDY from the cable, asynchronous |
| diorN | output | 2 | Per-channel read strobe, active low |
| diowN | output | 2 | Per-channel write strobe, active low |
| cycDone | output | 2 | Per-channel one-cycle completion pulse |

## Verification
A request sampled at edge k pulls the strobe low in the cycle right after that edge. The strobe rises after edge k+A, and `cycDone` is high in the cycle after edge k+A+R. The bench therefore counts low and high strobe samples taken at falling edges until it sees `cycDone`, which gives A and R directly without relying on absolute times.

Configuration reads are combinational and are sampled 1 ns after the address settles. A configuration write takes effect at the rising edge between the two falling edges of the write task.

For IORDY, the two synchronizer flops plus the state register mean exactly two more low samples follow the falling edge at which IORDY is raised, and the bench checks that count.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

  // Nibble, byte and word widths of the timing storage
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int WORD_W = 2 * BYTE_W;
  // Phase counter width and the bias values of the inverted encoding
  localparam int CNT_W    = 5;
  localparam int ACT_BIAS = 17;
  localparam int REC_BIAS = 16;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACTIVE  = 2'd1,
    PH_RECOVER = 2'd2
  } phase_t;

  // Strobes from the channel control to the channel datapath
  typedef struct packed {
    logic startCyc;     // latch unit timing and load active count
    logic loadRecover;  // load recovery count
    logic countDown;    // decrement phase counter
  } tmr_ctl_t;

  function automatic logic [CNT_W-1:0] decodeActive(input logic [NIB_W-1:0] nib);
    return CNT_W'(ACT_BIAS) - CNT_W'(nib);
  endfunction

  function automatic logic [CNT_W-1:0] decodeRecover(input logic [NIB_W-1:0] nib);
    return CNT_W'(REC_BIAS) - CNT_W'(nib);
  endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_timer_pkg::*;
#(
  parameter int                NUM_CHAN  = 2,
  parameter int                NUM_UNITS = 2 * NUM_CHAN,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] TIM_BASE  = 8'h44,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h42,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h43,
  parameter int                EN_LSB    = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [BYTE_W-1:0]                 wrData,
  input  logic [NUM_CHAN-1:0]               chanBusy,
  output logic [BYTE_W-1:0]                 rdData,
  output logic [NUM_UNITS-1:0][WORD_W-1:0]  timWords,
  output logic [NUM_UNITS-1:0]              unitEn
);

  localparam int NUM_BYTES = 2 * NUM_UNITS;

  logic [BYTE_W-1:0] timByte [NUM_BYTES];

  // One register per timing byte; reset value selects the slowest timing
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_tim
    always_ff @(posedge clk) begin
      if (!rstN) begin
        timByte[b] <= '0;
      end else if (wrEn && addr == ADDR_W'(TIM_BASE + b)) begin
        timByte[b] <= wrData;
      end
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_word
    assign timWords[u] = {timByte[2*u+1], timByte[2*u]};
  end

  // Enable flags change only when no write cycle is in flight
  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitEn <= '0;
    end else if (wrEn && addr == EN_ADDR && chanBusy == '0) begin
      unitEn <= wrData[EN_LSB +: NUM_UNITS];
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (addr == ADDR_W'(TIM_BASE + i)) rdData = timByte[i];
    end
    if (addr == EN_ADDR)   rdData[EN_LSB +: NUM_UNITS] = unitEn;
    if (addr == STAT_ADDR) rdData[NUM_CHAN-1:0]        = chanBusy;
  end

endmodule

// File: rtl/pio_chan_datapath.sv
module pio_chan_datapath
  import pio_timer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  tmr_ctl_t               ctl,
  input  logic                   reqDev,
  input  logic                   reqWrite,
  input  logic [1:0][WORD_W-1:0] timPair,
  input  logic [1:0]             enPair,
  input  logic                   iordyPin,
  output logic                   cntZero,
  output logic                   readyOk,
  output logic                   wrLatched
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [BYTE_W-1:0] selByte;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  recLat;
  logic              enLat;
  logic              wrLat;
  logic [1:0]        syncQ;

  // Pick the direction byte of the requested unit
  always_comb begin
    selByte = reqWrite ? timPair[reqDev][WORD_W-1:BYTE_W]
                       : timPair[reqDev][BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      recLat <= '0;
      enLat  <= 1'b0;
      wrLat  <= 1'b0;
      syncQ  <= '0;
    end else begin
      syncQ <= {syncQ[0], iordyPin};
      if (ctl.startCyc) begin
        cnt    <= decodeActive(selByte[NIB_W-1:0]) - ONE;
        recLat <= decodeRecover(selByte[BYTE_W-1:NIB_W]);
        enLat  <= enPair[reqDev];
        wrLat  <= reqWrite;
      end else if (ctl.loadRecover) begin
        cnt <= recLat - ONE;
      end else if (ctl.countDown) begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign cntZero   = (cnt == '0);
  assign readyOk   = enLat | syncQ[1];
  assign wrLatched = wrLat;

endmodule

// File: rtl/pio_chan_ctrl.sv
module pio_chan_ctrl
  import pio_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     req,
  input  logic     cntZero,
  input  logic     readyOk,
  input  logic     wrLatched,
  output tmr_ctl_t ctl,
  output logic     diorN,
  output logic     diowN,
  output logic     done,
  output logic     busy
);

  phase_t phase, phaseNext;
  logic   doneQ, doneNext;

  always_comb begin
    ctl       = '0;
    phaseNext = phase;
    doneNext  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (req) begin
          ctl.startCyc = 1'b1;
          phaseNext    = PH_ACTIVE;
        end
      end
      PH_ACTIVE: begin
        if (!cntZero) begin
          ctl.countDown = 1'b1;
        end else if (readyOk) begin
          ctl.loadRecover = 1'b1;
          phaseNext       = PH_RECOVER;
        end
      end
      PH_RECOVER: begin
        if (!cntZero) begin
          ctl.countDown = 1'b1;
        end else begin
          phaseNext = PH_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      doneQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      doneQ <= doneNext;
    end
  end

  assign diorN = !(phase == PH_ACTIVE && !wrLatched);
  assign diowN = !(phase == PH_ACTIVE &&  wrLatched);
  assign done  = doneQ;
  assign busy  = (phase != PH_IDLE) && wrLatched;

endmodule

// File: rtl/pata_pio_timer.sv
module pata_pio_timer
  import pio_timer_pkg::*;
#(
  parameter int                NUM_CHAN  = 2,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] TIM_BASE  = 8'h44,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h42,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h43,
  parameter int                EN_LSB    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [BYTE_W-1:0]   cfgWrData,
  output logic [BYTE_W-1:0]   cfgRdData,
  input  logic [NUM_CHAN-1:0] cycReq,
  input  logic [NUM_CHAN-1:0] cycDev,
  input  logic [NUM_CHAN-1:0] cycWrite,
  input  logic [NUM_CHAN-1:0] iordy,
  output logic [NUM_CHAN-1:0] diorN,
  output logic [NUM_CHAN-1:0] diowN,
  output logic [NUM_CHAN-1:0] cycDone
);

  localparam int NUM_UNITS = 2 * NUM_CHAN;

  logic [NUM_UNITS-1:0][WORD_W-1:0] timWords;
  logic [NUM_UNITS-1:0]             unitEn;
  logic [NUM_CHAN-1:0]              chanBusy;

  pio_cfg_regs #(
    .NUM_CHAN (NUM_CHAN),
    .NUM_UNITS(NUM_UNITS),
    .ADDR_W   (ADDR_W),
    .TIM_BASE (TIM_BASE),
    .EN_ADDR  (EN_ADDR),
    .STAT_ADDR(STAT_ADDR),
    .EN_LSB   (EN_LSB)
  ) u_cfg (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (cfgWrEn),
    .addr    (cfgAddr),
    .wrData  (cfgWrData),
    .chanBusy(chanBusy),
    .rdData  (cfgRdData),
    .timWords(timWords),
    .unitEn  (unitEn)
  );

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    tmr_ctl_t ctl;
    logic     cntZero, readyOk, wrLatched;

    pio_chan_datapath u_dp (
      .clk      (clk),
      .rstN     (rstN),
      .ctl      (ctl),
      .reqDev   (cycDev[c]),
      .reqWrite (cycWrite[c]),
      .timPair  (timWords[2*c +: 2]),
      .enPair   (unitEn[2*c +: 2]),
      .iordyPin (iordy[c]),
      .cntZero  (cntZero),
      .readyOk  (readyOk),
      .wrLatched(wrLatched)
    );

    pio_chan_ctrl u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .req      (cycReq[c]),
      .cntZero  (cntZero),
      .readyOk  (readyOk),
      .wrLatched(wrLatched),
      .ctl      (ctl),
      .diorN    (diorN[c]),
      .diowN    (diowN[c]),
      .done     (cycDone[c]),
      .busy     (chanBusy[c])
    );
  end

endmodule

// File: rtl/pio_timer_checker.sv
module pio_timer_checker #(
  parameter int NUM_CHAN  = 2,
  parameter int NUM_UNITS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CHAN-1:0]  diorN,
  input logic [NUM_CHAN-1:0]  diowN,
  input logic [NUM_CHAN-1:0]  cycDone,
  input logic [NUM_CHAN-1:0]  chanBusy,
  input logic [NUM_UNITS-1:0] unitEn
);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chk
    // R4: a channel never drives both strobes low
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
      !(!diorN[c] && !diowN[c]));

    // R3: completion is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
      cycDone[c] |=> !cycDone[c]);

    // R3: completion follows a recovery cycle with both strobes released
    a_r3_done_after_recovery: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cycDone[c]) |-> $past(diorN[c] && diowN[c]));

    // R7: a low write strobe implies the channel reports busy
    a_r7_busy_during_write: assert property (@(posedge clk) disable iff (!rstN)
      !diowN[c] |-> chanBusy[c]);
  end

  // R8: enable flags hold while any write cycle is in flight
  a_r8_enable_held: assert property (@(posedge clk) disable iff (!rstN)
    (|chanBusy) |=> $stable(unitEn));

endmodule

bind pata_pio_timer pio_timer_checker #(
  .NUM_CHAN (NUM_CHAN),
  .NUM_UNITS(NUM_UNITS)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .diorN   (diorN),
  .diowN   (diowN),
  .cycDone (cycDone),
  .chanBusy(chanBusy),
  .unitEn  (unitEn)
);

// File: tb/pata_pio_timer_bench.sv
module pata_pio_timer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = 8'h00;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic [1:0] cycReq = 2'b00;
  logic [1:0] cycDev = 2'b00;
  logic [1:0] cycWrite = 2'b00;
  logic [1:0] iordy = 2'b11;
  logic [1:0] diorN, diowN, cycDone;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pata_pio_timer u_pata_pio_timer (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .cycReq(cycReq), .cycDev(cycDev), .cycWrite(cycWrite), .iordy(iordy),
    .diorN(diorN), .diowN(diowN), .cycDone(cycDone)
  );

  typedef struct packed {
    logic [1:0] unit;
    logic       wr;
    logic [7:0] tbyte;
    logic [4:0] act;
    logic [4:0] rec;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{unit: 2'd0, wr: 1'b0, tbyte: 8'h00, act: 5'd17, rec: 5'd16},
    '{unit: 2'd1, wr: 1'b0, tbyte: 8'hFF, act: 5'd2,  rec: 5'd1},
    '{unit: 2'd2, wr: 1'b1, tbyte: 8'h3A, act: 5'd7,  rec: 5'd13},
    '{unit: 2'd3, wr: 1'b0, tbyte: 8'h95, act: 5'd12, rec: 5'd7},
    '{unit: 2'd0, wr: 1'b1, tbyte: 8'hC4, act: 5'd13, rec: 5'd4},
    '{unit: 2'd3, wr: 1'b1, tbyte: 8'h0E, act: 5'd3,  rec: 5'd16}
  };

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1;
    d = cfgRdData;
  endtask

  task automatic waitDone(input int ch);
    int n = 0;
    while (!cycDone[ch] && n < 300) begin n++; @(negedge clk); end
  endtask

  task automatic runCycle(input int ch, input int dev, input bit wr,
                          input int expAct, input int expRec, input string tag);
    int act = 0;
    int rec = 0;
    int stray = 0;
    @(negedge clk);
    cycReq[ch] = 1'b1; cycDev[ch] = dev[0]; cycWrite[ch] = wr;
    @(negedge clk);
    cycReq[ch] = 1'b0;
    while (((wr ? diowN[ch] : diorN[ch]) == 1'b0) && act < 300) begin
      act++;
      if ((wr ? diorN[ch] : diowN[ch]) == 1'b0) stray++;
      @(negedge clk);
    end
    while (!cycDone[ch] && rec < 300) begin rec++; @(negedge clk); end
    check(act == expAct, {tag, " active length"}, act, expAct);
    check(rec == expRec, {tag, " recovery length"}, rec, expRec);
    check(stray == 0, {tag, " other strobe stays high"}, stray, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int n;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(diorN == 2'b11 && diowN == 2'b11, "R1 strobes high", {diorN, diowN}, 15);
    check(cycDone == 2'b00, "R1 done low", cycDone, 0);
    for (int a = 8'h42; a <= 8'h4B; a++) begin
      cfgRead(8'(a), rd);
      check(rd == 8'h00, $sformatf("R1 reg 0x%0h", a), rd, 0);
    end

    // Table walk: R2 reads, R4 writes, R5 extremes, R11 unit select
    for (int i = 0; i < NVEC; i++) begin
      cfgWrite(8'(8'h44 + 2 * VECS[i].unit + VECS[i].wr), VECS[i].tbyte);
      runCycle(VECS[i].unit >> 1, VECS[i].unit & 1, VECS[i].wr,
               VECS[i].act, VECS[i].rec,
               $sformatf("%s R5 R11 vec%0d", VECS[i].wr ? "R4" : "R2", i));
    end

    // R6: IORDY low stretches the active phase of unit 0
    cfgWrite(8'h44, 8'hFE);
    iordy[0] = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge clk); cycReq[0] = 1'b1; cycDev[0] = 1'b0; cycWrite[0] = 1'b0;
    @(negedge clk); cycReq[0] = 1'b0;
    repeat (10) @(negedge clk);
    check(diorN[0] == 1'b0, "R6 strobe held while IORDY low", diorN[0], 0);
    iordy[0] = 1'b1;
    n = 0;
    @(negedge clk);
    while (!diorN[0] && n < 50) begin n++; @(negedge clk); end
    check(n == 2, "R6 release after IORDY sync", n, 2);
    waitDone(0);
    // R6: enable bit set, IORDY ignored
    iordy[0] = 1'b0;
    cfgWrite(8'h42, 8'h10);
    runCycle(0, 0, 1'b0, 3, 1, "R6 bypass");
    iordy[0] = 1'b1;

    // R7/R8: status during a write cycle, guarded enable write
    cfgWrite(8'h47, 8'h00);
    @(negedge clk); cycReq[0] = 1'b1; cycDev[0] = 1'b1; cycWrite[0] = 1'b1;
    @(negedge clk); cycReq[0] = 1'b0;
    cfgRead(8'h43, rd);
    check(rd == 8'h01, "R7 busy during write", rd, 1);
    cfgWrite(8'h42, 8'hF0);
    waitDone(0);
    cfgRead(8'h43, rd);
    check(rd == 8'h00, "R7 clear after write", rd, 0);
    cfgRead(8'h42, rd);
    check(rd == 8'h10, "R8 write ignored while busy", rd, 8'h10);
    cfgWrite(8'h42, 8'h30);
    cfgRead(8'h42, rd);
    check(rd == 8'h30, "R8 write taken when idle", rd, 8'h30);

    // R9: timing change mid-cycle applies to the next cycle only
    cfgWrite(8'h44, 8'h00);
    fork
      runCycle(0, 0, 1'b0, 17, 16, "R9 running cycle");
      begin repeat (4) @(negedge clk); cfgWrite(8'h44, 8'hFF); end
    join
    runCycle(0, 0, 1'b0, 2, 1, "R9 next cycle");

    // R10: both channels together with their own timing
    cfgWrite(8'h48, 8'hB8);
    fork
      runCycle(0, 0, 1'b0, 2, 1, "R10 ch0");
      runCycle(1, 0, 1'b0, 9, 5, "R10 ch1");
    join

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule